// File: doc/BRIEF.md
# Supply Threshold Detect Controller

This block is the digital half of a voltage supervisor. Two analog comparators sit outside it. One flags the core supply under its threshold, the other flags an external sense input under a fixed reference of about 1.21 V. Each comparator reaches the block as a single asynchronous bit that is high while the monitored level is below its threshold. The block synchronises both bits and picks one of them through a source bit. It keeps its output quiet for a settling window after it is switched on. A comparator state only counts once it has held for a minimum pulse width.

When the qualified state moves from "at or above" to "below", the block records a detection. A mode bit decides what the detection does. With the default mode it sets an interrupt request flag, and a mask bit gates that flag onto the interrupt line. With the other mode it issues a single-cycle reset request instead. A return to "at or above" is not an event: software sees it by polling the read-only level bit. Software works through a two-address, byte-wide register bus. Writes take effect at the clock edge and reads are combinational.

Top module: `lvd_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x00 and the interrupt register (address 1) reads 0x02 (bit 1 mask set, bit 0 request flag clear). Both irq_o and rst_req_o are low.
- R2: In the control register only bit 7 (enable), bit 2 (source: 1 = external input, 0 = supply) and bit 1 (action: 1 = reset request, 0 = interrupt) are writable. Other bits read 0, and bit 0 cannot be written.
- R3: After enable is set, the comparator is ignored for SETTLE_CYC clock cycles. A level that is already low at enable produces a detection only after the settling window plus the qualification time.
- R4: A comparator state shorter than QUAL_CYC cycles is discarded. It leaves the level bit and the request flag unchanged.
- R5: A "below" state held for QUAL_CYC cycles after settling sets control bit 0 to 1. With action 0 it also sets the request flag.
- R6: With action 1, a detection produces a one-cycle pulse on rst_req_o and leaves the request flag clear.
- R7: irq_o is high exactly when the request flag is set and the mask bit is clear. The flag is still set while masked.
- R8: Writing address 1 with bit 0 = 0 clears the request flag, and writing 1 there leaves it unchanged. Bit 1 of the same write sets the mask.
- R9: Clearing enable returns the block to idle. The request flag and the level bit clear, and a later enable restarts the settling window.
- R10: The source bit selects which comparator is monitored. The unselected one has no effect.
- R11: A qualified return to "at or above" clears control bit 0 and raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 interrupt |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cmp_vdd_low | input | 1 | Asynchronous supply comparator, 1 = below |
| cmp_ext_low | input | 1 | Asynchronous external-input comparator, 1 = below |
| irq_o | output | 1 | Interrupt request after masking |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The main function is tried with several comparator patterns:
- A level that is already low at enable. It shows whether the settling window adds to the qualification time or overlaps it.
- A low pulse shorter than the qualification time, and one longer than it. Together they locate the filter threshold.
- A qualified return to high. It separates the falling event from a plain level change.
- The same low pattern on the unselected comparator. It shows that source selection really isolates the two inputs.
- A detection repeated under reset mode, masked delivery and disable. These show that each path to the outputs is gated on its own.

// File: rtl/lvd_pkg.sv
// Package: shared register addresses, bit positions and control type for
// the supply threshold detect controller. Assumes a byte-wide register bus.
package lvd_pkg;
    localparam int REG_W      = 8;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_IRQ  = 1'b1;

    // control register bit positions
    localparam int CB_EN   = 7;
    localparam int CB_SRC  = 2;
    localparam int CB_ACT  = 1;
    localparam int CB_LVL  = 0;

    // interrupt register bit positions
    localparam int IB_FLAG = 0;
    localparam int IB_MASK = 1;

    typedef struct packed {
        logic en;       // detector enabled
        logic src_ext;  // 1: external input monitored
        logic act_rst;  // 1: reset request on detection
    } ctrl_t;
endpackage

// File: rtl/lvd_sync.sv
// Module: multi-stage synchroniser bringing an asynchronous comparator bit
// into the clock domain. Assumes the input is quasi-static relative to clk.
module lvd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lvd_qual.sv
// Module: settling timer and pulse-width qualifier. After en_i rises it
// ignores the input for SETTLE_CYC cycles, then accepts a new state only
// after it has held QUAL_CYC cycles. det_o pulses on a qualified move to
// "below". Assumes lvl_i is already synchronised.
module lvd_qual #(
    parameter int SETTLE_CYC = 10,
    parameter int QUAL_CYC   = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic lvl_i,
    output logic settled_o,
    output logic lvl_q_o,
    output logic det_o
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int QW = $clog2(QUAL_CYC + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);
    localparam logic [QW-1:0] QUAL_LAST   = QW'(QUAL_CYC - 1);

    logic [SW-1:0] settle_cnt;
    logic [QW-1:0] qual_cnt;
    logic          settled_q;
    logic          lvl_q;
    logic          det_q;
    logic          qual_done;

    assign qual_done = settled_q && (lvl_i != lvl_q) && (qual_cnt == QUAL_LAST);

    // settling window counter, restarted whenever the detector is disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            settle_cnt <= '0;
            settled_q  <= 1'b0;
        end else if (!settled_q) begin
            if (settle_cnt == SETTLE_LAST) settled_q <= 1'b1;
            else                           settle_cnt <= settle_cnt + 1'b1;
        end
    end

    // persistence counter and qualified level, frozen until settled
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || !settled_q) begin
            qual_cnt <= '0;
            lvl_q    <= 1'b0;
        end else if (lvl_i == lvl_q) begin
            qual_cnt <= '0;
        end else if (qual_done) begin
            qual_cnt <= '0;
            lvl_q    <= lvl_i;
        end else begin
            qual_cnt <= qual_cnt + 1'b1;
        end
    end

    // one-cycle pulse on a qualified falling crossing
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) det_q <= 1'b0;
        else                 det_q <= qual_done && lvl_i;
    end

    assign settled_o = settled_q;
    assign lvl_q_o   = lvl_q;
    assign det_o     = det_q;

    // R3: no detection while the settling window is open
    p_quiet_unsettled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !settled_q |=> !det_q);
    // R4: qualified level changes only after a full persistence count
    p_qual_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && $past(settled_q) && !$stable(lvl_q))
            |-> ($past(qual_cnt) == QUAL_LAST));
    // R9: disable drops the settled state
    p_disable_unsettle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !settled_q && !lvl_q);
endmodule

// File: rtl/lvd_regs.sv
// Module: register file and request logic. Holds the control bits, the
// interrupt flag and mask, and converts detections into an interrupt flag
// or a reset pulse. Assumes det_i is a single-cycle pulse.
module lvd_regs
    import lvd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             lvl_i,
    input  logic             det_i,
    output ctrl_t            ctrl_o,
    output logic             irq_o,
    output logic             rst_req_o
);
    ctrl_t ctrl_q;
    logic  mask_q;
    logic  flag_q;
    logic  rst_req_q;
    logic  wr_ctrl;
    logic  wr_irq;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_irq  = bus_wr && (bus_addr == ADDR_IRQ);

    // control register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.en      <= bus_wdata[CB_EN];
            ctrl_q.src_ext <= bus_wdata[CB_SRC];
            ctrl_q.act_rst <= bus_wdata[CB_ACT];
        end
    end

    // interrupt flag, mask and reset pulse; a detection wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= 1'b1;
            flag_q    <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= 1'b0;
            if (wr_irq) begin
                mask_q <= bus_wdata[IB_MASK];
                if (!bus_wdata[IB_FLAG]) flag_q <= 1'b0;
            end
            if (!ctrl_q.en) begin
                flag_q <= 1'b0;
            end else if (det_i) begin
                if (ctrl_q.act_rst) rst_req_q <= 1'b1;
                else                flag_q    <= 1'b1;
            end
        end
    end

    // combinational read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata[CB_EN]  = ctrl_q.en;
            bus_rdata[CB_SRC] = ctrl_q.src_ext;
            bus_rdata[CB_ACT] = ctrl_q.act_rst;
            bus_rdata[CB_LVL] = lvl_i;
        end else begin
            bus_rdata[IB_FLAG] = flag_q;
            bus_rdata[IB_MASK] = mask_q;
        end
    end

    assign ctrl_o    = ctrl_q;
    assign irq_o     = flag_q && !mask_q;
    assign rst_req_o = rst_req_q;

    // R5: the flag rises only from an interrupt-mode detection
    p_flag_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(det_i && ctrl_q.en && !ctrl_q.act_rst));
    // R6: reset request lasts one cycle
    p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_q |=> !rst_req_q);
    // R6: reset-mode detection produces the reset pulse
    p_rst_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (det_i && ctrl_q.en && ctrl_q.act_rst) |=> rst_req_q);
    // R9: disabled detector holds no pending request
    p_disable_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |=> !flag_q);
endmodule

// File: rtl/lvd_ctrl.sv
// Module: top of the supply threshold detect controller. Synchronises both
// comparator bits, selects one, qualifies it and drives interrupt or reset
// requests. Assumes CLK_HZ is the clk frequency; times are in microseconds.
module lvd_ctrl #(
    parameter int CLK_HZ    = 20_000_000,
    parameter int SETTLE_US = 10,
    parameter int QUAL_US   = 200,
    parameter int SYNC_STG  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       cmp_vdd_low,
    input  logic       cmp_ext_low,
    output logic       irq_o,
    output logic       rst_req_o
);
    import lvd_pkg::*;

    localparam longint SETTLE_RAW = (longint'(CLK_HZ) * SETTLE_US) / 1_000_000;
    localparam longint QUAL_RAW   = (longint'(CLK_HZ) * QUAL_US) / 1_000_000;
    localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : int'(SETTLE_RAW);
    localparam int QUAL_CYC   = (QUAL_RAW < 1) ? 1 : int'(QUAL_RAW);

    logic  [1:0] raw_low;
    logic  [1:0] sync_low;
    logic        sel_low;
    logic        settled;
    logic        lvl_q;
    logic        det;
    ctrl_t       ctrl;

    assign raw_low = {cmp_ext_low, cmp_vdd_low};

    // one synchroniser per comparator so a source switch sees settled data
    for (genvar g = 0; g < 2; g++) begin : g_sync
        lvd_sync #(.STAGES(SYNC_STG)) sync_i (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (raw_low[g]),
            .q_o  (sync_low[g])
        );
    end

    assign sel_low = ctrl.src_ext ? sync_low[1] : sync_low[0];

    lvd_qual #(.SETTLE_CYC(SETTLE_CYC), .QUAL_CYC(QUAL_CYC)) qual_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (ctrl.en),
        .lvl_i    (sel_low),
        .settled_o(settled),
        .lvl_q_o  (lvl_q),
        .det_o    (det)
    );

    lvd_regs regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .lvl_i    (lvl_q),
        .det_i    (det),
        .ctrl_o   (ctrl),
        .irq_o    (irq_o),
        .rst_req_o(rst_req_o)
    );

    // R7: interrupt line never active while the detector is off
    p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !$past(irq_o)) |-> $past(ctrl.en));
    // R3: no reset request before settling completes
    p_rst_after_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(settled, 2));
endmodule

// File: tb/lvd_ctrl_tb_top.sv
// Directed bench for lvd_ctrl: one task per scenario, each self-checking.
module lvd_ctrl_tb_top;
    // 1 MHz scaling gives SETTLE_CYC = 10 and QUAL_CYC = 200
    localparam int SET = 10;
    localparam int QUL = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cmp_vdd_low = 1'b0;
    logic       cmp_ext_low = 1'b0;
    logic       irq_o;
    logic       rst_req_o;

    int checks = 0;
    int failures = 0;
    int rst_seen = 0;

    always #2.5 clk = ~clk;

    lvd_ctrl #(.CLK_HZ(1_000_000)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_vdd_low(cmp_vdd_low), .cmp_ext_low(cmp_ext_low),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    // counts reset-request cycles seen on the port
    always @(negedge clk) if (rst_req_o) rst_seen++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset();
        cmp_vdd_low = 0; cmp_ext_low = 0;
        rst_n = 0; cyc(3); rst_n = 1; cyc(1);
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        do_reset();
        rd(1'b0, d); chk("R1 ctrl", d, 8'h00);
        rd(1'b1, d); chk("R1 irqreg", d, 8'h02);
        chk("R1 irq_o", irq_o, 0);
        chk("R1 rst_req_o", rst_req_o, 0);
    endtask

    task automatic t_ctrl_rw();
        logic [7:0] d;
        do_reset();
        wr(1'b0, 8'hFF); rd(1'b0, d); chk("R2 write ones", d, 8'h86);
        wr(1'b0, 8'h00); rd(1'b0, d); chk("R2 write zeros", d, 8'h00);
    endtask

    task automatic t_settle();
        logic [7:0] d;
        do_reset();
        wr(1'b1, 8'h00);            // unmask
        cmp_vdd_low = 1;
        cyc(5);
        wr(1'b0, 8'h80);            // enable, supply source, interrupt
        cyc(200);
        chk("R3 quiet during settle+qual", irq_o, 0);
        rd(1'b0, d); chk("R3 level still clear", d[0], 0);
        cyc(30);
        chk("R3 irq after settle+qual", irq_o, 1);
        rd(1'b0, d); chk("R5 level bit set", d[0], 1);
    endtask

    task automatic t_pulse_width();
        logic [7:0] d;
        do_reset();
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h80);
        cyc(SET + 10);
        cmp_vdd_low = 1; cyc(QUL - 40); cmp_vdd_low = 0;
        cyc(QUL + 20);
        chk("R4 short pulse irq", irq_o, 0);
        rd(1'b0, d); chk("R4 short pulse level", d[0], 0);
        rd(1'b1, d); chk("R4 short pulse flag", d[0], 0);
        cmp_vdd_low = 1; cyc(QUL + 20);
        chk("R5 long pulse irq", irq_o, 1);
        rd(1'b1, d); chk("R5 flag set", d[0], 1);
        // R11: qualified return high clears level, raises nothing new
        wr(1'b1, 8'h00);
        cmp_vdd_low = 0; cyc(QUL + 20);
        rd(1'b0, d); chk("R11 level cleared", d[0], 0);
        rd(1'b1, d); chk("R11 no new flag", d[0], 0);
    endtask

    task automatic t_mask_clear();
        logic [7:0] d;
        do_reset();                 // mask stays set after reset
        wr(1'b0, 8'h80);
        cmp_vdd_low = 1; cyc(SET + QUL + 30);
        chk("R7 masked irq low", irq_o, 0);
        rd(1'b1, d); chk("R7 flag set while masked", d, 8'h03);
        wr(1'b1, 8'h01);            // unmask, keep flag
        chk("R8 write 1 keeps flag", irq_o, 1);
        rd(1'b1, d); chk("R8 reg after unmask", d, 8'h01);
        wr(1'b1, 8'h00);            // clear flag
        chk("R8 cleared irq", irq_o, 0);
        rd(1'b1, d); chk("R8 reg after clear", d, 8'h00);
    endtask

    task automatic t_reset_mode();
        logic [7:0] d;
        do_reset();
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h82);            // enable, reset action
        rst_seen = 0;
        cmp_vdd_low = 1; cyc(SET + QUL + 30);
        chk("R6 one reset pulse", rst_seen, 1);
        chk("R6 no irq", irq_o, 0);
        rd(1'b1, d); chk("R6 flag clear", d[0], 0);
    endtask

    task automatic t_source();
        logic [7:0] d;
        do_reset();
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h84);            // enable, external source
        cmp_vdd_low = 1; cyc(SET + QUL + 30);
        chk("R10 unselected input ignored", irq_o, 0);
        rd(1'b0, d); chk("R10 level ignores supply", d[0], 0);
        cmp_ext_low = 1; cyc(QUL + 20);
        chk("R10 selected input detected", irq_o, 1);
    endtask

    task automatic t_disable();
        logic [7:0] d;
        do_reset();
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h80);
        cmp_vdd_low = 1; cyc(SET + QUL + 30);
        chk("R9 irq before disable", irq_o, 1);
        wr(1'b0, 8'h00);
        cyc(2);
        chk("R9 irq dropped", irq_o, 0);
        rd(1'b0, d); chk("R9 level cleared", d[0], 0);
        rd(1'b1, d); chk("R9 flag cleared", d[0], 0);
        wr(1'b0, 8'h80);            // re-enable with input still low
        cyc(200);
        chk("R9 settle restarts", irq_o, 0);
        cyc(30);
        chk("R9 detection after restart", irq_o, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_state();
        t_ctrl_rw();
        t_settle();
        t_pulse_width();
        t_mask_clear();
        t_reset_mode();
        t_source();
        t_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule